// File: doc/BRIEF.md
# Zero-Data Detector with Startup Mute Flag

This block watches a two-channel audio sample stream, one left and one right word per frame, and drives a single flag that tells the analog stages downstream that no signal is present. The frame boundary is the rising edge of the word clock. The block samples that clock in the system clock domain, and both channel words must be stable at that edge.

After reset the flag is held high. The block waits for the first rising edge of the word clock to align itself to the frame grid. It then sits through a fixed number of initialization frames. Only after that does it start judging data. From then on, the flag drops as soon as a frame carries any non-zero sample. The flag rises again only when the input has been all-zero for 2^RUN_BITS consecutive frames, which is about 0.37 s at a 44.1 kHz frame rate with the default. It stays high for as long as the zero run lasts. Analog muting itself is done outside this block.

Top module: `zero_run_flag`

## Requirements
- R1: While reset (rst_n LOW) is applied, `no_signal` is HIGH, and it is still HIGH on the first cycle after reset is released.
- R2: Frames seen before initialization ends do not clear the flag, even when they carry non-zero data. Initialization is the synchronizing frame plus INIT_FRAMES (default 8) further frames.
- R3: A frame is counted only on a LOW-to-HIGH transition of `word_clk` seen in the system clock domain. A `word_clk` that is already HIGH when reset is released is not a frame. Between frame edges `no_signal` does not change.
- R4: After initialization, the first frame carrying non-zero data drives `no_signal` LOW on the clock edge at which that frame's rising word-clock edge is detected. With the defaults this is the 10th rising edge after reset.
- R5: A frame counts as zero only when both `left_smp` and `right_smp` equal 0. A frame with only one non-zero channel clears the zero-run count.
- R6: After the flag has fallen, it rises on the 2^RUN_BITS-th consecutive zero frame (16384 by default) and not on any earlier frame.
- R7: Once HIGH through a zero run, `no_signal` stays HIGH for every further zero frame. The run count saturates and does not wrap.
- R8: A non-zero frame after a saturated run drives `no_signal` LOW again, and a fresh run of 2^RUN_BITS zero frames is then needed to raise it.
- R9: A reset applied in normal operation returns the block to the startup behaviour of R1 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word clock; each rising edge marks a frame |
| left_smp | input | SAMPLE_W | Left-channel sample, two's complement, valid at the frame edge |
| right_smp | input | SAMPLE_W | Right-channel sample, two's complement, valid at the frame edge |
| no_signal | output | 1 | HIGH while no signal is present (startup or long zero run) |

## Verification
The assertions check on every cycle that the flag is HIGH under reset and that it moves only in the cycle after a detected frame edge. They also check that it falls only after a frame carrying non-zero data, that it rises only when an independent count of zero frames has just reached the threshold, and that a zero frame never lowers it. The bench scenarios are needed for the rest. They show the exact number of initialization frames after the synchronizing edge and that a word clock held HIGH across reset is ignored. They also show the threshold boundary of 16383 versus 16384 zero frames, that a single-channel non-zero frame restarts the run, and that a reset in mid-operation brings back the startup sequence.

// File: rtl/zero_run_flag.sv
module zero_run_flag #(
  parameter int SAMPLE_W    = 16,
  parameter int RUN_BITS    = 14,
  parameter int INIT_FRAMES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_clk,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  output logic                no_signal
);

  localparam int RUN_W  = RUN_BITS + 1;
  localparam int INIT_W = $clog2(INIT_FRAMES + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(1) << RUN_BITS;
  localparam logic [INIT_W-1:0] INIT_END = INIT_W'(INIT_FRAMES - 1);

  typedef enum logic [1:0] {ST_WAIT, ST_INIT, ST_RUN} state_t;

  state_t            state;
  logic              wc_q;
  logic [INIT_W-1:0] init_cnt;
  logic [RUN_W-1:0]  run_cnt;

  wire frame_tick = word_clk & ~wc_q;
  wire frame_zero = (left_smp == '0) && (right_smp == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q      <= 1'b1;
      state     <= ST_WAIT;
      init_cnt  <= '0;
      run_cnt   <= RUN_MAX;
      no_signal <= 1'b1;
    end else begin
      wc_q <= word_clk;
      if (frame_tick) begin
        case (state)
          ST_WAIT: begin
            state    <= ST_INIT;
            init_cnt <= '0;
          end
          ST_INIT: begin
            if (init_cnt == INIT_END) state <= ST_RUN;
            else init_cnt <= init_cnt + INIT_W'(1);
          end
          ST_RUN: begin
            if (!frame_zero) begin
              run_cnt   <= '0;
              no_signal <= 1'b0;
            end else if (run_cnt != RUN_MAX) begin
              run_cnt   <= run_cnt + RUN_W'(1);
              no_signal <= (run_cnt == RUN_MAX - RUN_W'(1));
            end
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/zero_run_flag_chk.sv
module zero_run_flag_chk #(
  parameter int SAMPLE_W    = 16,
  parameter int RUN_BITS    = 14,
  parameter int INIT_FRAMES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                word_clk,
  input logic [SAMPLE_W-1:0] left_smp,
  input logic [SAMPLE_W-1:0] right_smp,
  input logic                no_signal
);

  localparam int RUN_W = RUN_BITS + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(1) << RUN_BITS;

  logic             wc_prev;
  logic [RUN_W-1:0] zrun;

  wire edge_seen = word_clk && !wc_prev;
  wire data_zero = (left_smp == '0) && (right_smp == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_prev <= 1'b1;
      zrun    <= '0;
    end else begin
      wc_prev <= word_clk;
      if (edge_seen) begin
        if (!data_zero) zrun <= '0;
        else if (zrun != RUN_MAX) zrun <= zrun + RUN_W'(1);
      end
    end
  end

  always @(posedge clk)
    if (rst_n === 1'b0)
      AST_RESET_FLAG: assert (no_signal === 1'b1); // R1

  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |=> $stable(no_signal)); // R3

  AST_FALL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_signal) |-> ($past(left_smp) != '0 || $past(right_smp) != '0)); // R4

  AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_signal) |-> (zrun == RUN_MAX)); // R6

  AST_ZERO_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (no_signal && edge_seen && data_zero) |=> no_signal); // R7

endmodule

bind zero_run_flag zero_run_flag_chk #(
  .SAMPLE_W(SAMPLE_W), .RUN_BITS(RUN_BITS), .INIT_FRAMES(INIT_FRAMES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_clk(word_clk),
  .left_smp(left_smp), .right_smp(right_smp), .no_signal(no_signal)
);

// File: tb/tb_zero_run_flag.sv
module tb_zero_run_flag;
  localparam int THRESH = 1 << 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        word_clk = 1'b0;
  logic [15:0] left_smp = '0;
  logic [15:0] right_smp = '0;
  logic        no_signal;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  zero_run_flag dut (
    .clk(clk), .rst_n(rst_n), .word_clk(word_clk),
    .left_smp(left_smp), .right_smp(right_smp), .no_signal(no_signal)
  );

  task automatic check(input logic exp, input string tag);
    n_checks++;
    if (no_signal !== exp) begin
      n_fail++;
      $display("FAIL %s: no_signal actual=%b expected=%b", tag, no_signal, exp);
    end
  endtask

  // one frame: word clock high for one cycle, low for two; result visible afterwards
  task automatic frame(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    left_smp = l; right_smp = r; word_clk = 1'b1;
    @(negedge clk);
    word_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) frame(16'h0000, 16'h0000);
  endtask

  task automatic t_reset_startup;
    @(negedge clk);
    rst_n = 1'b0;
    word_clk = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b1, "R1 flag under reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, "R1 flag just after reset release");
    repeat (5) @(negedge clk);
    word_clk = 1'b0;
    @(negedge clk);
    check(1'b1, "R3 held-high word clock is no frame");
    frame(16'h1234, 16'h0001);
    check(1'b1, "R2 sync frame with data keeps flag");
    for (int i = 0; i < 8; i++) frame(16'h7FFF, 16'h8000);
    check(1'b1, "R2 init frames with data keep flag");
    frame(16'h0000, 16'h0000);
    check(1'b1, "R4 first data frame zero keeps flag");
    frame(16'h0042, 16'h0000);
    check(1'b0, "R4 first non-zero data frame clears flag");
  endtask

  task automatic t_threshold;
    zeros(16000);
    check(1'b0, "R6 16000 zero frames still low");
    frame(16'h0000, 16'h0005);
    check(1'b0, "R5 right-only non-zero frame keeps low");
    zeros(THRESH - 1);
    check(1'b0, "R5 R6 run restarted, 16383 zeros still low");
    zeros(1);
    check(1'b1, "R6 16384th zero frame raises flag");
    zeros(20);
    check(1'b1, "R7 flag stays high through more zeros");
  endtask

  task automatic t_release;
    frame(16'hFFFF, 16'h0000);
    check(1'b0, "R8 left-only non-zero frame clears flag");
    zeros(1000);
    check(1'b0, "R8 fresh run needed after clear");
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b1, "R9 reset in operation raises flag");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 9; i++) frame(16'h0100, 16'h0100);
    check(1'b1, "R9 startup frames ignored again");
    frame(16'h0100, 16'h0000);
    check(1'b0, "R9 first data frame after re-init clears flag");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    t_reset_startup();
    t_threshold();
    t_release();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule